// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps wall-clock time and calendar date as seven packed-BCD registers: seconds, minutes, hours, day of week, date, month (with a century flag in its top bit) and a two-digit year. A free-running pulse input `tickIn` feeds an internal prescaler. Every `TICKS_PER_SEC` pulses the time moves on by one second. The carry then ripples through minutes, hours, day of week, date, month and year within the same clock edge. The date wraps at the true end of each month, and February gets its 29th day in every year whose value is a multiple of four.

The hours register has two encodings, chosen by its bit 6. Clear gives a 24-hour count. Set gives a 12-hour count with an AM/PM flag in bit 5. A host write port loads any of the seven registers directly. Such a load also restarts the prescaler, so the next second begins at the moment of the load. On each second the block raises a one-cycle strobe, `updStrobe`, alongside the new values, so that alarm comparison logic downstream knows when to sample.

Top module: `clk_cal_top`

## Requirements
- R1: After reset the registers read: seconds 00h, minutes 00h, hours 00h, day of week 01h, date 01h, month 01h, year 00h. `updStrobe` reads 0.
- R2: The time advances by one second on the clock edge that samples the `TICKS_PER_SEC`-th `tickIn` pulse counted since reset or since the last load. Fewer pulses change nothing. Idle cycles between pulses do not count. On the cycle after that edge, `updStrobe` is 1 and the registers show the new time. On the following cycle `updStrobe` is 0 again.
- R3: Seconds and minutes count in BCD from 00h to 59h. A value of 59h wraps to 00h and carries into the next field.
- R4: With hours bit 6 = 0, hours count in BCD from 00h to 23h. Going from 23:59:59 gives 00:00:00 and advances the day.
- R5: With hours bit 6 = 1, hours bits 4:0 hold a BCD hour in the order 12, 01, 02 … 11. Bit 5 is 1 for PM. Bit 5 flips when the hour goes from 11 to 12. 11:59:59 PM becomes 12:00:00 AM (hours byte 52h) and advances the day. Bit 6 keeps its value.
- R6: The day of week counts 1 to 7. It goes up by one whenever the day advances, and 7 wraps to 1.
- R7: When the day advances, a date equal to the month's length wraps to 01h and the month goes up by one. Otherwise the date goes up by one in BCD. Month lengths are 31 for months 01, 03, 05, 07, 08, 10h, 12h and 30 for 04, 06, 09, 11h. February has 29 days when the binary year value is a multiple of four (00 included) and 28 days otherwise.
- R8: Month 12h wraps to 01h and advances the year. Year 99h wraps to 00h, and in that same step month bit 7 (the century flag) inverts. Month bit 7 does not change at any other advance.
- R9: A write with `wrEn` = 1 loads `wrData` ANDed with a per-register mask. The addresses and masks are: address 0 seconds (7Fh), 1 minutes (7Fh), 2 hours (7Fh), 3 day of week (07h), 4 date (3Fh), 5 month (9Fh), 6 year (FFh). A write to address 7 changes no register.
- R10: A write to addresses 0 to 6 zeroes the prescaler phase. A `tickIn` pulse in the same cycle as such a write is discarded. The next advance therefore needs `TICKS_PER_SEC` further pulses.
- R11: The registers change only on an advance or a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickIn | input | 1 | Prescaler pulse, one cycle per pulse |
| wrEn | input | 1 | Host register write enable |
| wrAddr | input | 3 | Host register address |
| wrData | input | 8 | Host register write data |
| secReg | output | 8 | Seconds, BCD |
| minReg | output | 8 | Minutes, BCD |
| hourReg | output | 8 | Hours, BCD, bit 6 mode, bit 5 PM or tens |
| dowReg | output | 8 | Day of week 1 to 7 |
| dateReg | output | 8 | Date, BCD |
| monReg | output | 8 | Month BCD in bits 4:0, century flag in bit 7 |
| yearReg | output | 8 | Year, BCD |
| updStrobe | output | 1 | One-cycle pulse with each new second |

## Verification
A wrong prescaler phase shows within one second of stimulus as a strobe that arrives one or more pulses early or late. A wrong limit decode in the carry chain stays hidden until that field next rolls over, which can be hours or years of simulated time away. The bench therefore loads the registers to one second before each boundary and checks all seven outputs one cycle after the advancing edge. This covers every month in leap and common years, all 24 hours in both hour encodings, every day-of-week value and both century states. Write masking and the discarding of pulses are seen directly at the register outputs once the write cycle has passed.

// File: rtl/clk_cal_pkg.sv
package clk_cal_pkg;

  localparam int NUM_REGS = 7;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 8;

  typedef enum logic [ADDR_W-1:0] {
    IDX_SEC  = 3'd0,
    IDX_MIN  = 3'd1,
    IDX_HOUR = 3'd2,
    IDX_DOW  = 3'd3,
    IDX_DATE = 3'd4,
    IDX_MON  = 3'd5,
    IDX_YEAR = 3'd6
  } regIdx_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                incSec;
    logic                incMin;
    logic                incHour;
    logic                incDay;
    logic                incMonth;
    logic                incYear;
    logic [NUM_REGS-1:0] wrSel;
    logic [DATA_W-1:0]   wrData;
  } calCtl_t;

  // field-at-limit flags from datapath to control
  typedef struct packed {
    logic secAtMax;
    logic minAtMax;
    logic hourAtMax;
    logic dateAtMax;
    logic monAtMax;
  } calLimit_t;

  function automatic logic [DATA_W-1:0] writeMask(input int idx);
    case (idx)
      0, 1, 2: return 8'h7F;
      3:       return 8'h07;
      4:       return 8'h3F;
      5:       return 8'h9F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcdToBin(input logic [7:0] v);
    return ({3'b000, v[7:4]} * 7'd10) + {3'b000, v[3:0]};
  endfunction

endpackage

// File: rtl/clk_cal_ctl.sv
module clk_cal_ctl
  import clk_cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  calLimit_t         lim,
  output calCtl_t           ctl,
  output logic              updStrobe
);

  logic                wrHit;
  logic                secTick;
  logic [NUM_REGS-1:0] wrSel;

  assign wrHit = wrEn && (wrAddr < ADDR_W'(NUM_REGS));

  generate
    if (TICKS_PER_SEC <= 1) begin : g_direct
      assign secTick = tickIn & ~wrHit;
    end else begin : g_prescale
      localparam int PS_W = $clog2(TICKS_PER_SEC);
      localparam logic [PS_W-1:0] PS_LAST = PS_W'(TICKS_PER_SEC - 1);
      logic [PS_W-1:0] phase;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)           phase <= '0;
        else if (wrHit)      phase <= '0;
        else if (tickIn)     phase <= (phase == PS_LAST) ? '0 : phase + 1'b1;
      end

      assign secTick = tickIn & ~wrHit & (phase == PS_LAST);
    end
  endgenerate

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    assign wrSel[i] = wrEn && (wrAddr == ADDR_W'(i));
  end

  always_comb begin
    ctl          = '0;
    ctl.incSec   = secTick;
    ctl.incMin   = secTick      & lim.secAtMax;
    ctl.incHour  = ctl.incMin   & lim.minAtMax;
    ctl.incDay   = ctl.incHour  & lim.hourAtMax;
    ctl.incMonth = ctl.incDay   & lim.dateAtMax;
    ctl.incYear  = ctl.incMonth & lim.monAtMax;
    ctl.wrSel    = wrSel;
    ctl.wrData   = wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) updStrobe <= 1'b0;
    else       updStrobe <= secTick;
  end

endmodule

// File: rtl/clk_cal_dp.sv
module clk_cal_dp
  import clk_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  calCtl_t           ctl,
  output calLimit_t         lim,
  output logic [DATA_W-1:0] secReg,
  output logic [DATA_W-1:0] minReg,
  output logic [DATA_W-1:0] hourReg,
  output logic [DATA_W-1:0] dowReg,
  output logic [DATA_W-1:0] dateReg,
  output logic [DATA_W-1:0] monReg,
  output logic [DATA_W-1:0] yearReg
);

  logic       mode12;
  logic       isLeap;
  logic       yearAtMax;
  logic [7:0] monthDays;
  logic [6:0] yearBin;
  logic [7:0] secNext, minNext, hourNext, dowNext, dateNext, monNext, yearNext;

  assign mode12  = hourReg[6];
  assign yearBin = bcdToBin(yearReg);
  assign isLeap  = (yearBin[1:0] == 2'b00);

  // month length in BCD
  always_comb begin
    case (monReg[4:0])
      5'h02:                      monthDays = isLeap ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: monthDays = 8'h30;
      default:                    monthDays = 8'h31;
    endcase
  end

  always_comb begin
    lim.secAtMax  = (secReg == 8'h59);
    lim.minAtMax  = (minReg == 8'h59);
    lim.hourAtMax = mode12 ? (hourReg[5] && hourReg[4:0] == 5'h11)
                           : (hourReg[5:0] == 6'h23);
    lim.dateAtMax = (dateReg == monthDays);
    lim.monAtMax  = (monReg[4:0] == 5'h12);
  end
  assign yearAtMax = (yearReg == 8'h99);

  // next-value logic per field
  always_comb begin
    logic [7:0] hInc;
    secNext  = lim.secAtMax  ? 8'h00 : bcdInc(secReg);
    minNext  = lim.minAtMax  ? 8'h00 : bcdInc(minReg);
    dateNext = lim.dateAtMax ? 8'h01 : bcdInc(dateReg);
    yearNext = yearAtMax     ? 8'h00 : bcdInc(yearReg);
    dowNext  = (dowReg[2:0] == 3'd7) ? 8'h01 : {5'b0, dowReg[2:0] + 3'd1};
    monNext  = {monReg[7] ^ (ctl.incYear & yearAtMax), 2'b00,
                lim.monAtMax ? 5'h01 : bcdInc({3'b0, monReg[4:0]})[4:0]};
    hInc     = bcdInc({3'b0, hourReg[4:0]});
    if (mode12) begin
      if (hourReg[4:0] == 5'h12)      hourNext = {2'b01, hourReg[5], 5'h01};
      else if (hourReg[4:0] == 5'h11) hourNext = {2'b01, ~hourReg[5], 5'h12};
      else                            hourNext = {2'b01, hourReg[5], hInc[4:0]};
    end else begin
      hourNext = lim.hourAtMax ? 8'h00 : bcdInc({2'b00, hourReg[5:0]});
    end
  end

  // register bank: write wins over advance
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secReg  <= 8'h00;
      minReg  <= 8'h00;
      hourReg <= 8'h00;
      dowReg  <= 8'h01;
      dateReg <= 8'h01;
      monReg  <= 8'h01;
      yearReg <= 8'h00;
    end else begin
      if (ctl.wrSel[IDX_SEC])       secReg  <= ctl.wrData & writeMask(IDX_SEC);
      else if (ctl.incSec)          secReg  <= secNext;
      if (ctl.wrSel[IDX_MIN])       minReg  <= ctl.wrData & writeMask(IDX_MIN);
      else if (ctl.incMin)          minReg  <= minNext;
      if (ctl.wrSel[IDX_HOUR])      hourReg <= ctl.wrData & writeMask(IDX_HOUR);
      else if (ctl.incHour)         hourReg <= hourNext;
      if (ctl.wrSel[IDX_DOW])       dowReg  <= ctl.wrData & writeMask(IDX_DOW);
      else if (ctl.incDay)          dowReg  <= dowNext;
      if (ctl.wrSel[IDX_DATE])      dateReg <= ctl.wrData & writeMask(IDX_DATE);
      else if (ctl.incDay)          dateReg <= dateNext;
      if (ctl.wrSel[IDX_MON])       monReg  <= ctl.wrData & writeMask(IDX_MON);
      else if (ctl.incMonth)        monReg  <= monNext;
      if (ctl.wrSel[IDX_YEAR])      yearReg <= ctl.wrData & writeMask(IDX_YEAR);
      else if (ctl.incYear)         yearReg <= yearNext;
    end
  end

endmodule

// File: rtl/clk_cal_top.sv
module clk_cal_top
  import clk_cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] secReg,
  output logic [DATA_W-1:0] minReg,
  output logic [DATA_W-1:0] hourReg,
  output logic [DATA_W-1:0] dowReg,
  output logic [DATA_W-1:0] dateReg,
  output logic [DATA_W-1:0] monReg,
  output logic [DATA_W-1:0] yearReg,
  output logic              updStrobe
);

  calCtl_t   ctl;
  calLimit_t lim;

  clk_cal_ctl #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_ctl (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .lim(lim), .ctl(ctl),
    .updStrobe(updStrobe)
  );

  clk_cal_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .lim(lim),
    .secReg(secReg), .minReg(minReg), .hourReg(hourReg), .dowReg(dowReg),
    .dateReg(dateReg), .monReg(monReg), .yearReg(yearReg)
  );

endmodule

// File: rtl/clk_cal_chk.sv
module clk_cal_chk #(
  parameter int TICKS_PER_SEC = 32768
) (
  input logic       clk,
  input logic       rstN,
  input logic       tickIn,
  input logic       wrEn,
  input logic [7:0] secReg,
  input logic [7:0] minReg,
  input logic [7:0] hourReg,
  input logic [7:0] dowReg,
  input logic [7:0] dateReg,
  input logic [7:0] monReg,
  input logic [7:0] yearReg,
  input logic       updStrobe
);

  // R2
  strobe_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    updStrobe |-> ($past(tickIn) && !$past(wrEn)));

  generate
    if (TICKS_PER_SEC > 1) begin : g_spacing
      // R2
      strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
        updStrobe |=> !updStrobe);
    end
  endgenerate

  // R3
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updStrobe && $past(secReg) == 8'h59) |-> (secReg == 8'h00));

  // R11
  hold_regs_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!updStrobe && !$past(wrEn)) |->
      $stable({secReg, minReg, hourReg, dowReg, dateReg, monReg, yearReg}));

  // R5
  hour_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(hourReg[6]) |-> $past(wrEn));

  // R6
  dow_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updStrobe && $past(dowReg) == 8'h07 && !$stable(dowReg)) |-> (dowReg == 8'h01));

  // R8
  century_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(monReg[7]) |->
      ($past(wrEn) || (updStrobe && yearReg == 8'h00 && monReg[4:0] == 5'h01)));

endmodule

bind clk_cal_top clk_cal_chk #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_chk (
  .clk(clk), .rstN(rstN), .tickIn(tickIn), .wrEn(wrEn),
  .secReg(secReg), .minReg(minReg), .hourReg(hourReg), .dowReg(dowReg),
  .dateReg(dateReg), .monReg(monReg), .yearReg(yearReg), .updStrobe(updStrobe)
);

// File: tb/tb_clk_cal_top.sv
`timescale 1ns/1ps
module tb_clk_cal_top;

  localparam int TPS = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickIn = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] secReg, minReg, hourReg, dowReg, dateReg, monReg, yearReg;
  logic       updStrobe;

  int checks = 0;
  int errors = 0;

  // reference model (binary)
  int ms, mm, mh, mdow, md, mmo, my;
  bit m12, mcent;

  always #5 clk = ~clk;

  clk_cal_top #(.TICKS_PER_SEC(TPS)) dut (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .secReg(secReg), .minReg(minReg), .hourReg(hourReg),
    .dowReg(dowReg), .dateReg(dateReg), .monReg(monReg), .yearReg(yearReg),
    .updStrobe(updStrobe)
  );

  function automatic logic [7:0] toBcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int daysIn(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] expHour();
    int h12;
    if (!m12) return toBcd(mh);
    h12 = (mh % 12 == 0) ? 12 : mh % 12;
    return {2'b01, (mh >= 12) ? 1'b1 : 1'b0, toBcd(h12)[4:0]};
  endfunction

  task automatic chk(string req, string name, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", req, name, act, exp);
    end
  endtask

  task automatic compareAll(string req);
    chk(req, "sec",   secReg,  toBcd(ms));
    chk(req, "min",   minReg,  toBcd(mm));
    chk(req, "hour",  hourReg, expHour());
    chk(req, "dow",   dowReg,  8'(mdow));
    chk(req, "date",  dateReg, toBcd(md));
    chk(req, "month", monReg,  {mcent, 2'b00, toBcd(mmo)[4:0]});
    chk(req, "year",  yearReg, toBcd(my));
  endtask

  task automatic modelStep();
    ms++;
    if (ms == 60) begin ms = 0; mm++; end
    if (mm == 60) begin mm = 0; mh++; end
    if (mh == 24) begin
      mh = 0;
      mdow = (mdow == 7) ? 1 : mdow + 1;
      md++;
      if (md > daysIn(mmo, my)) begin md = 1; mmo++; end
      if (mmo == 13) begin mmo = 1; my++; end
      if (my == 100) begin my = 0; mcent = ~mcent; end
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk);
    tickIn = 1'b1;
    @(negedge clk);
    tickIn = 1'b0;
  endtask

  task automatic second();
    repeat (TPS) pulse();
  endtask

  task automatic setTime(int s, int m, int h, bit mode, int dw, int d, int mo, int y, bit c);
    ms = s; mm = m; mh = h; m12 = mode; mdow = dw; md = d; mmo = mo; my = y; mcent = c;
    wr(3'd0, toBcd(s));
    wr(3'd1, toBcd(m));
    wr(3'd2, expHour());
    wr(3'd3, 8'(dw));
    wr(3'd4, toBcd(d));
    wr(3'd5, {c, 2'b00, toBcd(mo)[4:0]});
    wr(3'd6, toBcd(y));
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int yrs[5] = '{0, 3, 4, 48, 97};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    ms = 0; mm = 0; mh = 0; m12 = 0; mdow = 1; md = 1; mmo = 1; my = 0; mcent = 0;
    compareAll("R1");
    chk("R1", "strobe", {7'b0, updStrobe}, 8'h00);

    // R2 partial prescale then advance
    repeat (TPS - 1) pulse();
    chk("R2", "sec-partial", secReg, 8'h00);
    chk("R2", "strobe-partial", {7'b0, updStrobe}, 8'h00);
    pulse();
    chk("R2", "sec-adv", secReg, 8'h01);
    chk("R2", "strobe-on", {7'b0, updStrobe}, 8'h01);
    @(negedge clk);
    chk("R2", "strobe-off", {7'b0, updStrobe}, 8'h00);
    modelStep();

    // R3 sweep of seconds through two minutes
    for (int i = 0; i < 125; i++) begin
      second();
      modelStep();
      compareAll("R3");
    end

    // R4 every hour in 24-hour mode
    for (int h = 0; h < 24; h++) begin
      setTime(59, 59, h, 1'b0, 2, 10, 3, 21, 1'b0);
      second(); modelStep(); compareAll("R4");
    end

    // R5 every hour in 12-hour mode
    for (int h = 0; h < 24; h++) begin
      setTime(59, 59, h, 1'b1, 2, 10, 3, 21, 1'b0);
      second(); modelStep(); compareAll("R5");
    end

    // R6 day-of-week wrap
    for (int d = 1; d <= 7; d++) begin
      setTime(59, 59, 23, 1'b0, d, 15, 6, 21, 1'b0);
      second(); modelStep(); compareAll("R6");
    end

    // R7 every month end, leap and common years
    for (int mo = 1; mo <= 12; mo++) begin
      foreach (yrs[k]) begin
        setTime(59, 59, 23, 1'b0, 4, daysIn(mo, yrs[k]), mo, yrs[k], 1'b0);
        second(); modelStep(); compareAll("R7");
      end
    end
    // R7 day before end of February in leap year 00
    setTime(59, 59, 23, 1'b0, 4, 28, 2, 0, 1'b0);
    second(); modelStep(); compareAll("R7");

    // R8 year wrap with both century states
    setTime(59, 59, 23, 1'b0, 5, 31, 12, 99, 1'b0);
    second(); modelStep(); compareAll("R8");
    setTime(59, 59, 23, 1'b0, 5, 31, 12, 99, 1'b1);
    second(); modelStep(); compareAll("R8");
    setTime(59, 59, 23, 1'b0, 5, 31, 12, 42, 1'b1);
    second(); modelStep(); compareAll("R8");

    // R9 write masks and ignored address 7
    for (int a = 0; a < 7; a++) wr(3'(a), 8'hFF);
    chk("R9", "sec-mask",  secReg,  8'h7F);
    chk("R9", "min-mask",  minReg,  8'h7F);
    chk("R9", "hour-mask", hourReg, 8'h7F);
    chk("R9", "dow-mask",  dowReg,  8'h07);
    chk("R9", "date-mask", dateReg, 8'h3F);
    chk("R9", "mon-mask",  monReg,  8'h9F);
    chk("R9", "year-mask", yearReg, 8'hFF);
    setTime(10, 20, 5, 1'b0, 3, 12, 8, 33, 1'b0);
    wr(3'd7, 8'h55);
    compareAll("R9");

    // R10 write restarts the prescaler phase
    repeat (TPS - 2) pulse();
    wr(3'd0, 8'h30); ms = 30;
    repeat (TPS - 1) pulse();
    compareAll("R10");
    chk("R10", "strobe-held", {7'b0, updStrobe}, 8'h00);
    pulse(); modelStep();
    compareAll("R10");
    // R10 tick in the write cycle is discarded
    @(negedge clk);
    wrEn = 1'b1; tickIn = 1'b1; wrAddr = 3'd0; wrData = 8'h40;
    @(negedge clk);
    wrEn = 1'b0; tickIn = 1'b0; ms = 40;
    repeat (TPS - 1) pulse();
    compareAll("R10");
    pulse(); modelStep();
    compareAll("R10");

    // R11 idle cycles change nothing
    repeat (20) @(negedge clk);
    compareAll("R11");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule